// File: doc/BRIEF.md
# 8-bit Shift and Rotate Unit

This block performs the four one-place shift and rotate operations of a small accumulator processor. The operations are a shift up that fills the low bit with zero, a shift down that fills the high bit with zero, and two rotates that feed the incoming carry into the vacated end. Every operation reports the bit that falls off the end as the new carry. It also drives a negative flag and a zero flag. The operand arrives on one input byte. The surrounding datapath places either the accumulator or the byte captured by a read-modify-write memory sequence on that input.

The unit has two modes. In accumulator mode one operand strobe registers the result and all three flags at once, and that step ends the instruction. In memory mode the operand strobe registers the modified byte and the carry. The negative and zero flags keep their old values until a separate sequence-complete strobe. That strobe derives them from the held result. The result register thus serves as the accumulator write-back value and as the write-back byte of the memory sequence.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (shift up) gives result bit i = operand bit i-1 with bit 0 = 0, ignoring the carry input.
- R2: Operation code 1 (shift down) gives result bit i = operand bit i+1 with the top bit = 0, ignoring the carry input.
- R3: Operation code 2 (rotate up) gives the shift-up result with bit 0 taken from the carry input held before the instruction, not from the newly computed carry.
- R4: Operation code 3 (rotate down) gives the shift-down result with the top bit taken from the carry input held before the instruction.
- R5: On an operand strobe the carry flag becomes the operand's original top bit for codes 0 and 2, and its original bit 0 for codes 1 and 3.
- R6: With mode 0 (accumulator), the result, carry, negative and zero outputs all update on the clock edge that samples the operand strobe. Negative equals the result's top bit, and zero is 1 exactly when the result is all zeros.
- R7: With mode 1 (memory), an operand strobe updates the result and carry on its edge and leaves negative and zero unchanged.
- R8: A sequence-complete strobe without an operand strobe sets negative to the top bit of the held result and zero to whether the held result is all zeros. Result and carry are left unchanged.
- R9: In a cycle with neither strobe, the result and all three flags hold their values.
- R10: While reset is low, the result and all flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 2 | Operation code: 0 shift up, 1 shift down, 2 rotate up, 3 rotate down |
| mem_mode | input | 1 | 0 accumulator mode, 1 memory mode |
| opnd_vld | input | 1 | Operand strobe; operand is sampled this cycle |
| seq_done | input | 1 | Memory sequence complete strobe |
| carry_in | input | 1 | Carry held before the instruction |
| opnd | input | WIDTH | Operand byte |
| result | output | WIDTH | Registered result / write-back byte |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the unit at its default width of eight bits. At that width, each end-of-byte case can be driven with a hand-picked vector: a one falling off each end, a result that collapses to zero, and a full byte rotated with a clear incoming carry. That last case shows the stale carry being used rather than the new one. The eight-bit build also lets one memory-mode sequence show the carry moving at the modify step while negative and zero hold until completion.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [1:0] {
      SR_SHL = 2'd0,
      SR_SHR = 2'd1,
      SR_RL  = 2'd2,
      SR_RR  = 2'd3
   } sr_op_e;

   typedef enum logic {
      SR_ACC = 1'b0,
      SR_MEM = 1'b1
   } sr_mode_e;

   function automatic logic sr_goes_up(input sr_op_e op);
      return (op == SR_SHL) || (op == SR_RL);
   endfunction

   function automatic logic sr_rotates(input sr_op_e op);
      return (op == SR_RL) || (op == SR_RR);
   endfunction

endpackage

// File: rtl/shrot_core.sv
module shrot_core
   import shrot_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  sr_op_e           op,
   input  logic             cin,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             cout
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("shrot_core: WIDTH must be at least 2");
   end

   logic up;
   logic fill_lo;
   logic fill_hi;

   always_comb begin
      up      = sr_goes_up(op);
      fill_lo = (op == SR_RL) ? cin : 1'b0;
      fill_hi = (op == SR_RR) ? cin : 1'b0;
      cout    = up ? din[MSB] : din[0];
   end

   // One slice per bit: pick the lower or upper neighbour, or the fill at the ends
   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      logic from_below;
      logic from_above;
      if (i == 0) begin : g_lo_end
         assign from_below = fill_lo;
      end else begin : g_lo_mid
         assign from_below = din[i-1];
      end
      if (i == MSB) begin : g_hi_end
         assign from_above = fill_hi;
      end else begin : g_hi_mid
         assign from_above = din[i+1];
      end
      assign dout[i] = up ? from_below : from_above;
   end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_c,
   input  logic             c_next,
   input  logic             ld_nz,
   input  logic [WIDTH-1:0] nz_src,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c
);

   localparam int MSB = WIDTH - 1;

   logic n_next;
   logic z_next;

   always_comb begin
      n_next = nz_src[MSB];
      z_next = ~|nz_src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         flag_c <= 1'b0;
      end else begin
         if (ld_c) flag_c <= c_next;
         if (ld_nz) begin
            flag_n <= n_next;
            flag_z <= z_next;
         end
      end
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op_sel,
   input  logic             mem_mode,
   input  logic             opnd_vld,
   input  logic             seq_done,
   input  logic             carry_in,
   input  logic [WIDTH-1:0] opnd,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c
);

   if (WIDTH < 2) begin : g_bad_width
      $error("shrot_unit: WIDTH must be at least 2");
   end

   sr_op_e           op;
   sr_mode_e         mode;
   logic [WIDTH-1:0] core_out;
   logic             core_c;
   logic             acc_step;
   logic             nz_load;
   logic [WIDTH-1:0] nz_src;

   always_comb begin
      op       = sr_op_e'(op_sel);
      mode     = sr_mode_e'(mem_mode);
      acc_step = opnd_vld && (mode == SR_ACC);
      // accumulator step takes N/Z from the fresh result; completion takes them from the held byte
      nz_load  = acc_step || (seq_done && !opnd_vld);
      nz_src   = acc_step ? core_out : result;
   end

   shrot_core #(.WIDTH(WIDTH)) i_core (
      .op   (op),
      .cin  (carry_in),
      .din  (opnd),
      .dout (core_out),
      .cout (core_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) result <= '0;
      else if (opnd_vld) result <= core_out;
   end

   shrot_flags #(.WIDTH(WIDTH)) i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_c   (opnd_vld),
      .c_next (core_c),
      .ld_nz  (nz_load),
      .nz_src (nz_src),
      .flag_n (flag_n),
      .flag_z (flag_z),
      .flag_c (flag_c)
   );

endmodule

// File: rtl/shrot_chk.sv
module shrot_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       op_sel,
   input logic             mem_mode,
   input logic             opnd_vld,
   input logic             seq_done,
   input logic             carry_in,
   input logic [WIDTH-1:0] opnd,
   input logic [WIDTH-1:0] result,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c
);

   // R1
   shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_vld && op_sel == 2'd0) |=> (result == {$past(opnd[WIDTH-2:0]), 1'b0}));

   // R4
   rr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_vld && op_sel == 2'd3) |=> (result == {$past(carry_in), $past(opnd[WIDTH-1:1])}));

   // R5
   carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_vld |=> (flag_c == ($past(op_sel[0]) ? $past(opnd[0]) : $past(opnd[WIDTH-1]))));

   // R6
   acc_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_vld && !mem_mode) |=> (flag_n == result[WIDTH-1] && flag_z == (result == '0)));

   // R7
   mem_nz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_vld && mem_mode) |=> ($stable(flag_n) && $stable(flag_z)));

   // R8
   done_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !opnd_vld) |=> (flag_n == $past(result[WIDTH-1]) &&
                                   flag_z == ($past(result) == '0) && $stable(result)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!opnd_vld && !seq_done) |=> ($stable(result) && $stable(flag_n) &&
                                    $stable(flag_z) && $stable(flag_c)));

endmodule

bind shrot_unit shrot_chk #(.WIDTH(WIDTH)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_sel   (op_sel),
   .mem_mode (mem_mode),
   .opnd_vld (opnd_vld),
   .seq_done (seq_done),
   .carry_in (carry_in),
   .opnd     (opnd),
   .result   (result),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_c   (flag_c)
);

// File: tb/test_shrot_unit.sv
module test_shrot_unit;

   localparam int W = 8;
   localparam int NV = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   op_sel = '0;
   logic         mem_mode = 1'b0;
   logic         opnd_vld = 1'b0;
   logic         seq_done = 1'b0;
   logic         carry_in = 1'b0;
   logic [W-1:0] opnd = '0;
   logic [W-1:0] result;
   logic         flag_n, flag_z, flag_c;

   int n_run = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   shrot_unit #(.WIDTH(W)) i_shrot_unit (.*);

   // {op, cin, operand, result, C, N, Z}, accumulator mode
   localparam logic [21:0] VEC [NV] = '{
      {2'd0, 1'b0, 8'h81, 8'h02, 1'b1, 1'b0, 1'b0},  // R1 R5
      {2'd0, 1'b1, 8'h80, 8'h00, 1'b1, 1'b0, 1'b1},  // R1 carry ignored
      {2'd0, 1'b0, 8'h40, 8'h80, 1'b0, 1'b1, 1'b0},  // R1 R6
      {2'd1, 1'b1, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1},  // R2 carry ignored
      {2'd1, 1'b0, 8'hFE, 8'h7F, 1'b0, 1'b0, 1'b0},  // R2
      {2'd1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},  // R2 R6
      {2'd2, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, 1'b1},  // R3
      {2'd2, 1'b1, 8'h40, 8'h81, 1'b0, 1'b1, 1'b0},  // R3
      {2'd2, 1'b0, 8'hFF, 8'hFE, 1'b1, 1'b1, 1'b0},  // R3 stale carry
      {2'd3, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1},  // R4
      {2'd3, 1'b1, 8'h02, 8'h81, 1'b0, 1'b1, 1'b0},  // R4
      {2'd3, 1'b0, 8'hFF, 8'h7F, 1'b1, 1'b0, 1'b0}   // R4 stale carry
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic strobe(input logic [1:0] op, input logic md, input logic ci,
                         input logic [W-1:0] d);
      @(negedge clk);
      op_sel = op; mem_mode = md; carry_in = ci; opnd = d; opnd_vld = 1'b1;
      @(negedge clk);
      opnd_vld = 1'b0;
   endtask

   task automatic finish_seq();
      @(negedge clk);
      seq_done = 1'b1;
      @(negedge clk);
      seq_done = 1'b0;
   endtask

   initial begin
      #1000000;
      n_run++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10
      chk("R10 result", result, 0);
      chk("R10 flags", {flag_n, flag_z, flag_c}, 3'b000);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         strobe(VEC[k][21:20], 1'b0, VEC[k][19], VEC[k][18:11]);
         chk($sformatf("R1-4 vec%0d result", k), result, VEC[k][10:3]);
         chk($sformatf("R5 vec%0d carry", k), flag_c, VEC[k][2]);
         chk($sformatf("R6 vec%0d nz", k), {flag_n, flag_z}, VEC[k][1:0]);
      end

      // R9: idle cycles hold everything (last vector left 7F, C=1, N=0, Z=0)
      repeat (3) @(negedge clk);
      chk("R9 hold result", result, 8'h7F);
      chk("R9 hold flags", {flag_n, flag_z, flag_c}, 3'b001);

      // set N=0 Z=1 C=1 via accumulator step
      strobe(2'd0, 1'b0, 1'b0, 8'h80);
      chk("R6 setup nz", {flag_n, flag_z, flag_c}, 3'b011);
      // R7: memory modify step, rotate up C0 with cin 0 -> 80, C=1, N/Z held
      strobe(2'd2, 1'b1, 1'b0, 8'hC0);
      chk("R7 mem result", result, 8'h80);
      chk("R7 mem carry", flag_c, 1'b1);
      chk("R7 nz held", {flag_n, flag_z}, 2'b01);
      @(negedge clk);
      chk("R9 mem idle", {flag_n, flag_z}, 2'b01);
      // R8: completion loads N/Z from held byte
      finish_seq();
      chk("R8 nz from byte", {flag_n, flag_z}, 2'b10);
      chk("R8 result kept", result, 8'h80);
      chk("R8 carry kept", flag_c, 1'b1);

      // R7/R8 zero result in memory mode: shift down 01 -> 00, C=1
      strobe(2'd1, 1'b1, 1'b1, 8'h01);
      chk("R7 mem zero carry", flag_c, 1'b1);
      chk("R7 nz held 2", {flag_n, flag_z}, 2'b10);
      finish_seq();
      chk("R8 zero flag", {flag_n, flag_z}, 2'b01);

      // R4 in memory mode with rotate down and cin 1
      strobe(2'd3, 1'b1, 1'b1, 8'h00);
      chk("R4 mem rotate", result, 8'h80);
      chk("R5 mem carry", flag_c, 1'b0);
      finish_seq();
      chk("R8 neg flag", {flag_n, flag_z}, 2'b10);

      // R10: reset again clears state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 re-reset", {result, flag_n, flag_z, flag_c}, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule